// File: doc/BRIEF.md
# NOR Flash Array Program and Erase Engine

This block holds a byte-wide on-chip storage array and gives it the write rules of NOR flash. A command sequencer in front of it hands over single-byte program requests and erase requests, and it reads bytes back through a registered read port. In the default mode a program can only turn bits from 1 to 0: the stored byte becomes the old byte ANDed with the new data. A configuration input switches to an overwrite mode, in which the new data replaces the stored byte, as an EEPROM would.

An erase sets a whole region to 0xFF. The region is chosen by an erase kind: a small block, a medium block, one sector, or the whole array. The engine writes one byte per clock and holds `busy` high while it runs. Each region size is a power of two and is clipped to the array size. The start address is rounded down to the region size. Two capability inputs say whether the small and medium sizes are supported. If an unsupported size is requested, the erase still runs but an error pulse is raised. Erase and program requests both need the write-enable latch input. Requests that arrive while the engine is busy are refused with a reject pulse.

After reset the engine wipes the whole array to 0xFF, keeping `busy` high while it does so. The array holds SECTOR_BYTES × SECTOR_COUNT bytes, and both of these parameters must be powers of two.

Top module: `nor_array_engine`

## Requirements
- R1: After reset is released, `busy` stays high for exactly ARRAY_BYTES cycles while the array is filled. After that, every byte reads 0xFF. During reset, `rd_data` is 0xFF and all pulse outputs are low.
- R2: `rd_data` shows the byte stored at the `rd_addr` value sampled on the previous rising clock edge.
- R3: In normal mode (`cfg_overwrite` = 0), an accepted program stores (old byte AND `prog_data`).
- R4: `raise_warn` pulses for one cycle, starting the cycle after an accepted normal-mode program, when `prog_data` has a 1 in a bit position where the stored byte has a 0. It stays low otherwise.
- R5: With `cfg_overwrite` = 1, an accepted program stores `prog_data` unchanged and never raises `raise_warn`.
- R6: With `wel` low, program and erase requests change no byte and do not raise `busy`.
- R7: `erase_kind` encoding: 0 = small block (SMALL_ERASE_BYTES), 1 = medium block (MID_ERASE_BYTES), 2 = one sector (SECTOR_BYTES), 3 = whole array. Each size is clipped to ARRAY_BYTES. The region starts at `erase_addr` rounded down to a multiple of its size. Every byte in the region becomes 0xFF, and no byte outside it changes.
- R8: An accepted erase keeps `busy` high for exactly as many cycles as the region has bytes. `busy` goes high from the cycle after the request.
- R9: `erase_unsup` pulses one cycle after an idle-time erase request of kind 0 with `cfg_can_small` low, or of kind 1 with `cfg_can_mid` low. This happens whether or not `wel` is set. If `wel` is set, the erase still runs.
- R10: A program or erase request made while `busy` is high has no effect on memory or on the erase length. It raises `busy_reject` for one cycle.
- R11: When a program request and an accepted erase arrive in the same idle cycle, the erase runs, the program is dropped, and `busy_reject` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the fill to 0xFF |
| cfg_overwrite | input | 1 | 1 = a program replaces the byte; 0 = a program ANDs into the byte |
| cfg_can_small | input | 1 | Small-block erase is supported |
| cfg_can_mid | input | 1 | Medium-block erase is supported |
| wel | input | 1 | Write-enable latch; gates program and erase |
| prog_valid | input | 1 | Program request strobe |
| prog_addr | input | AW | Byte address for the program |
| prog_data | input | 8 | Data to program |
| erase_valid | input | 1 | Erase request strobe |
| erase_addr | input | AW | Any address inside the region to erase |
| erase_kind | input | 2 | Erase size selector (see R7) |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Fill or erase in progress |
| busy_reject | output | 1 | A request was refused (one-cycle pulse) |
| erase_unsup | output | 1 | An unsupported erase size was requested (one-cycle pulse) |
| raise_warn | output | 1 | A program tried to set a 0 bit back to 1 (one-cycle pulse) |

## Verification
The bench builds the engine with 32-byte sectors and eight of them, giving a 256-byte array. The small block is set to 8 bytes and the medium block to 512 bytes. With an array this small, every byte can be programmed twice and every byte can be read back after each erase, so each erase is shown to touch no byte outside its region. The oversized medium block exercises clipping to the array size. Erases of 8, 32 and 256 cycles let the bench count `busy` exactly and inject refused requests in the middle of an erase.

// File: rtl/nor_eng_pkg.sv
package nor_eng_pkg;

  typedef enum logic [1:0] {
    ERASE_SMALL  = 2'd0,
    ERASE_MID    = 2'd1,
    ERASE_SECTOR = 2'd2,
    ERASE_WHOLE  = 2'd3
  } erase_kind_e;

  // Region length clipped to the array.
  function automatic int unsigned clip_span(input int unsigned want, input int unsigned limit);
    return (want > limit) ? limit : want;
  endfunction

  // New stored byte after a program.
  function automatic logic [7:0] merge_byte(input logic [7:0] old_b, input logic [7:0] new_b,
                                            input logic overwrite);
    return overwrite ? new_b : (old_b & new_b);
  endfunction

  // True when the data asks for a 0 -> 1 transition somewhere.
  function automatic logic raises_bits(input logic [7:0] old_b, input logic [7:0] new_b);
    return |(new_b & ~old_b);
  endfunction

endpackage

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int unsigned AW       = 8,
  parameter int unsigned FILL_LEN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW:0]   start_len,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);
  logic [AW:0]   remain;
  logic [AW-1:0] cursor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= (AW+1)'(FILL_LEN);
      cursor <= '0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
      cursor <= cursor + 1'b1;
    end else if (start) begin
      remain <= start_len;
      cursor <= start_addr;
    end
  end

  assign busy    = (remain != '0);
  assign wr_en   = busy;
  assign wr_addr = cursor;
endmodule

// File: rtl/nor_byte_store.sv
module nor_byte_store #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'hFF;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nor_prog_path.sv
module nor_prog_path
  import nor_eng_pkg::*;
(
  input  logic       fire,
  input  logic       overwrite,
  input  logic [7:0] old_byte,
  input  logic [7:0] new_data,
  output logic [7:0] merged,
  output logic       bit_raise
);
  assign merged    = merge_byte(old_byte, new_data, overwrite);
  assign bit_raise = fire & ~overwrite & raises_bits(old_byte, new_data);
endmodule

// File: rtl/nor_array_engine.sv
module nor_array_engine
  import nor_eng_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES      = 256,
  parameter int unsigned SECTOR_COUNT      = 8,
  parameter int unsigned SMALL_ERASE_BYTES = 4096,
  parameter int unsigned MID_ERASE_BYTES   = 32768,
  localparam int unsigned ARRAY_BYTES      = SECTOR_BYTES * SECTOR_COUNT,
  localparam int unsigned AW               = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_overwrite,
  input  logic          cfg_can_small,
  input  logic          cfg_can_mid,
  input  logic          wel,
  input  logic          prog_valid,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          erase_valid,
  input  logic [AW-1:0] erase_addr,
  input  logic [1:0]    erase_kind,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          busy_reject,
  output logic          erase_unsup,
  output logic          raise_warn
);
  localparam int unsigned LW        = AW + 1;
  localparam int unsigned LEN_SMALL = clip_span(SMALL_ERASE_BYTES, ARRAY_BYTES);
  localparam int unsigned LEN_MID   = clip_span(MID_ERASE_BYTES, ARRAY_BYTES);
  localparam int unsigned LEN_SECT  = clip_span(SECTOR_BYTES, ARRAY_BYTES);

  erase_kind_e   kind;
  logic [LW-1:0] erase_len;
  logic [AW-1:0] erase_mask;
  logic [AW-1:0] erase_start;

  // Named internal events (also observed by the checker).
  logic          erase_take;
  logic          prog_fire;
  logic          reject_evt;
  logic          unsup_evt;
  logic          seq_wr;
  logic [AW-1:0] seq_addr;
  logic [7:0]    old_byte;
  logic [7:0]    merged;
  logic          bit_raise;
  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [7:0]    st_wdata;

  assign kind = erase_kind_e'(erase_kind);

  always_comb begin
    unique case (kind)
      ERASE_SMALL:  erase_len = LW'(LEN_SMALL);
      ERASE_MID:    erase_len = LW'(LEN_MID);
      ERASE_SECTOR: erase_len = LW'(LEN_SECT);
      default:      erase_len = LW'(ARRAY_BYTES);
    endcase
  end

  assign erase_mask  = ~(AW'(erase_len - 1'b1));
  assign erase_start = erase_addr & erase_mask;

  assign erase_take = erase_valid & ~busy & wel;
  assign prog_fire  = prog_valid & wel & ~busy & ~erase_valid;
  assign reject_evt = ((prog_valid | erase_valid) & busy) | (prog_valid & erase_take);
  assign unsup_evt  = erase_valid & ~busy &
                      (((kind == ERASE_SMALL) & ~cfg_can_small) |
                       ((kind == ERASE_MID)   & ~cfg_can_mid));

  nor_erase_seq #(.AW(AW), .FILL_LEN(ARRAY_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (erase_take),
    .start_addr (erase_start),
    .start_len  (erase_len),
    .busy       (busy),
    .wr_en      (seq_wr),
    .wr_addr    (seq_addr)
  );

  nor_prog_path u_prog (
    .fire      (prog_fire),
    .overwrite (cfg_overwrite),
    .old_byte  (old_byte),
    .new_data  (prog_data),
    .merged    (merged),
    .bit_raise (bit_raise)
  );

  assign st_we    = seq_wr | prog_fire;
  assign st_waddr = seq_wr ? seq_addr : prog_addr;
  assign st_wdata = seq_wr ? 8'hFF : merged;

  nor_byte_store #(.AW(AW), .DEPTH(ARRAY_BYTES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (st_we),
    .waddr     (st_waddr),
    .wdata     (st_wdata),
    .peek_addr (prog_addr),
    .peek_data (old_byte),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_reject <= 1'b0;
      erase_unsup <= 1'b0;
      raise_warn  <= 1'b0;
    end else begin
      busy_reject <= reject_evt;
      erase_unsup <= unsup_evt;
      raise_warn  <= bit_raise;
    end
  end
endmodule

// File: rtl/nor_array_engine_chk.sv
module nor_array_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic wel,
  input logic cfg_overwrite,
  input logic prog_valid,
  input logic erase_valid,
  input logic busy,
  input logic busy_reject,
  input logic erase_unsup,
  input logic raise_warn,
  input logic prog_fire,
  input logic seq_wr
);
  // R10: the program path never writes while the sequencer owns the array
  p_no_prog_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_fire);

  // R11: the two write sources never drive the store together
  p_single_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_fire, seq_wr}));

  // R10 / R11: a reject follows a busy request or a same-cycle collision
  p_reject_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_reject |-> ($past(busy) || $past(prog_valid && erase_valid)));

  // R6: an erase only starts with the write-enable latch set
  p_erase_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel) && $past(erase_valid));

  // R9: the unsupported-size pulse always follows an erase request
  p_unsup_from_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_unsup |-> $past(erase_valid));

  // R4 / R5: warnings come only from normal-mode programs
  p_warn_normal_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    raise_warn |-> ($past(prog_fire) && !$past(cfg_overwrite)));
endmodule

bind nor_array_engine nor_array_engine_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wel           (wel),
  .cfg_overwrite (cfg_overwrite),
  .prog_valid    (prog_valid),
  .erase_valid   (erase_valid),
  .busy          (busy),
  .busy_reject   (busy_reject),
  .erase_unsup   (erase_unsup),
  .raise_warn    (raise_warn),
  .prog_fire     (prog_fire),
  .seq_wr        (seq_wr)
);

// File: tb/nor_array_engine_test.sv
module nor_array_engine_test;
  localparam int SEC   = 32;
  localparam int NSEC  = 8;
  localparam int SMALL = 8;
  localparam int MID   = 512;
  localparam int ARR   = SEC * NSEC;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_overwrite = 1'b0, cfg_can_small = 1'b1, cfg_can_mid = 1'b1, wel = 1'b0;
  logic prog_valid = 1'b0, erase_valid = 1'b0;
  logic [AW-1:0] prog_addr = '0, erase_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0;
  logic [1:0] erase_kind = '0;
  logic [7:0] rd_data;
  logic busy, busy_reject, erase_unsup, raise_warn;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [ARR];

  always #5 clk = ~clk;

  nor_array_engine #(.SECTOR_BYTES(SEC), .SECTOR_COUNT(NSEC),
                     .SMALL_ERASE_BYTES(SMALL), .MID_ERASE_BYTES(MID)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_overwrite(cfg_overwrite),
    .cfg_can_small(cfg_can_small), .cfg_can_mid(cfg_can_mid), .wel(wel),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_valid(erase_valid), .erase_addr(erase_addr), .erase_kind(erase_kind),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .busy_reject(busy_reject),
    .erase_unsup(erase_unsup), .raise_warn(raise_warn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int span_of(input int kind);
    int want;
    case (kind)
      0: want = SMALL;
      1: want = MID;
      2: want = SEC;
      default: want = ARR;
    endcase
    return (want < ARR) ? want : ARR;
  endfunction

  task automatic read_chk(input int a, input string req);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(rd_data == model[a], req, rd_data, model[a]);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < ARR; a++) read_chk(a, req);
  endtask

  task automatic prog(input int a, input int d, input string req);
    logic [7:0] old_b, exp_b;
    bit exp_w;
    old_b = model[a];
    exp_b = cfg_overwrite ? 8'(d) : (old_b & 8'(d));
    exp_w = wel && !cfg_overwrite && ((8'(d) & ~old_b) != 0);
    prog_addr = AW'(a); prog_data = 8'(d); prog_valid = 1'b1;
    @(negedge clk);
    prog_valid = 1'b0;
    chk(raise_warn == exp_w, {req, " warn"}, raise_warn, exp_w);
    if (wel) model[a] = exp_b;
  endtask

  // Erase and count busy cycles; inject refused requests mid-way if asked.
  task automatic erase(input int a, input int kind, input bit exp_unsup,
                       input bit inject, input string req);
    int len, start, cnt;
    len   = wel ? span_of(kind) : 0;
    start = (a / span_of(kind)) * span_of(kind);
    erase_addr = AW'(a); erase_kind = 2'(kind); erase_valid = 1'b1;
    @(negedge clk);
    erase_valid = 1'b0;
    chk(erase_unsup == exp_unsup, {req, " unsup"}, erase_unsup, exp_unsup);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (inject && cnt == 3) begin
        prog_addr = AW'(100); prog_data = 8'h00; prog_valid = 1'b1;
      end else if (inject && cnt == 4) begin
        prog_valid = 1'b0;
        chk(busy_reject == 1'b1, "R10 program while busy", busy_reject, 1);
        erase_kind = 2'd3; erase_addr = '0; erase_valid = 1'b1;
      end else if (inject && cnt == 5) begin
        erase_valid = 1'b0;
        chk(busy_reject == 1'b1, "R10 erase while busy", busy_reject, 1);
      end
      @(negedge clk);
    end
    chk(cnt == len, {req, " busy length R8"}, cnt, len);
    for (int i = 0; i < len; i++) model[start + i] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < ARR; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_data == 8'hFF, "R1 reset rd_data", rd_data, 8'hFF);
    chk({busy_reject, erase_unsup, raise_warn} == 3'b000, "R1 reset pulses",
        {busy_reject, erase_unsup, raise_warn}, 0);
    rst_n = 1'b1;
    begin
      int cnt;
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
      chk(cnt == ARR, "R1 fill length", cnt, ARR);
    end
    sweep("R1 filled array");

    wel = 1'b1;
    // R3 / R4 / R5 directed
    prog(3, 8'h5A, "R3 first program");
    read_chk(3, "R2 R3 readback 5A");
    prog(3, 8'h0F, "R4 raise attempt");
    read_chk(3, "R3 AND result");
    prog(3, 8'h0A, "R4 no raise");
    cfg_overwrite = 1'b1;
    prog(3, 8'hF0, "R5 overwrite");
    read_chk(3, "R5 overwrite result");
    cfg_overwrite = 1'b0;

    // R3 / R4 sweep: two passes over every byte
    for (int a = 0; a < ARR; a++) prog(a, a ^ 8'h3C, "R3 pass one");
    for (int a = 0; a < ARR; a++) prog(a, (a * 7) & 8'hFF, "R4 pass two");
    sweep("R3 after passes");

    // R6: latch clear
    wel = 1'b0;
    prog(10, 8'h00, "R6 program without latch");
    read_chk(10, "R6 program ignored");
    erase(0, 3, 1'b0, 1'b0, "R6 erase without latch");
    read_chk(0, "R6 erase ignored");
    cfg_can_mid = 1'b0;
    erase(20, 1, 1'b1, 1'b0, "R9 unsupported without latch");
    cfg_can_mid = 1'b1;
    wel = 1'b1;

    // R7 / R8 small erase, aligned down
    erase(13, 0, 1'b0, 1'b0, "R7 small erase");
    sweep("R7 small region only");

    // R9 unsupported small still executes
    cfg_can_small = 1'b0;
    erase(45, 0, 1'b1, 1'b0, "R9 unsupported small");
    cfg_can_small = 1'b1;
    sweep("R9 erase still ran");

    // R10 sector erase with refused requests injected
    erase(70, 2, 1'b0, 1'b1, "R7 sector erase");
    sweep("R10 refused requests no effect");

    // R11 collision
    prog_addr = AW'(5); prog_data = 8'h00; prog_valid = 1'b1;
    erase_addr = AW'(200); erase_kind = 2'd0; erase_valid = 1'b1;
    @(negedge clk);
    prog_valid = 1'b0; erase_valid = 1'b0;
    chk(busy_reject == 1'b1, "R11 collision reject", busy_reject, 1);
    chk(busy == 1'b1, "R11 erase started", busy, 1);
    while (busy) @(negedge clk);
    for (int i = 200; i < 208; i++) model[i] = 8'hFF;
    sweep("R11 program dropped");

    // R7 medium clipped to array, then whole erase
    erase(130, 1, 1'b0, 1'b0, "R7 medium clipped");
    sweep("R7 clipped all FF");
    prog(17, 8'h11, "R3 refill");
    prog(250, 8'h22, "R3 refill");
    erase(9, 3, 1'b0, 1'b0, "R7 whole erase");
    sweep("R7 whole all FF");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule